// File: doc/BRIEF.md
# Parallel Port Receive Interface

This peripheral sits between a host-side parallel printer port and an embedded CPU. It watches the host's active-low strobe through a synchroniser. On the strobe's leading (falling) edge it raises BUSY toward the host. On the trailing (rising) edge it copies the eight data lines into a holding register, marks a byte as pending and raises a level interrupt to the CPU.

The CPU gets the byte only by reading the data register. The block never lets go of the host by itself. Firmware writes a command to release the port, and the block then drives the active-low acknowledge line for a fixed number of clock cycles and drops BUSY at the end of that pulse. Firmware can also force BUSY high, for example while its buffer is full or while it prints a line, and keep it high until it clears the force. A strobe that arrives while BUSY is high is dropped, and a sticky overrun flag records it.

Register map (two-bit word address, read data returned registered one cycle after the request): address 0 reads the held byte. Address 1 reads status: bit0 byte pending, bit1 BUSY, bit2 forced busy, bit3 overrun. Writing 1 to bit3 of address 1 clears overrun. Address 2 is write-only commands: bit0 acknowledge and release, bit1 set forced busy, bit2 clear forced busy.

Top module: `pp_rx_port`

## Requirements
- R1: After reset, host_busy is 0, host_ack_n is 1, irq is 0 and the status register (address 1) reads 0.
- R2: A falling edge on host_strobe_n, seen through a two-stage synchroniser, drives host_busy high. host_data is captured when the strobe rises again, and a read of address 0 returns that byte in bus_rdata on the cycle after the read request.
- R3: irq is high exactly while a byte is pending. Pending is set by a capture and cleared by a read of address 0. If a capture and a data read fall in the same cycle, pending stays set and that read returns the previously held byte.
- R4: Writing address 2 with bit0 set while a captured byte is held drives host_ack_n low for ACK_CYCLES clock cycles (default 8), starting the cycle after the write. The same write has no effect when no byte is held.
- R5: At the end of the acknowledge pulse host_busy falls, unless forced busy is set.
- R6: Writing address 2 with bit1 set sets forced busy, and writing bit2 clears it (set wins if both are written). host_busy stays high while forced busy is set.
- R7: A strobe falling edge that arrives while host_busy is high captures nothing, leaves the held byte and the pending flag unchanged, and sets the sticky overrun flag (status bit3). Writing 1 to bit3 of address 1 clears the flag.
- R8: The status register at address 1 reports bit0 pending, bit1 host_busy, bit2 forced busy and bit3 overrun, with bits above bit3 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| host_data | input | DATA_W | Host data lines |
| host_busy | output | 1 | Busy toward the host |
| host_ack_n | output | 1 | Acknowledge toward the host, active low |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt while a byte is pending |

## Verification
The two functions that can meet in one cycle are the capture of a new byte, which sets pending, and a CPU read of the data register, which clears it. The bench acknowledges a byte without reading it, sends a second byte, and places a data read on exactly the clock edge where the synchronised strobe rise causes the capture. It then expects the read to return the first byte, irq to stay high, and a second read to return the new byte.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

    typedef enum logic [1:0] {
        HS_IDLE      = 2'd0,
        HS_WAIT_RISE = 2'd1,
        HS_HOLD      = 2'd2,
        HS_ACK       = 2'd3
    } hs_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;

    localparam int CMD_BIT_RELEASE = 0;
    localparam int CMD_BIT_FSET    = 1;
    localparam int CMD_BIT_FCLR    = 2;
    localparam int STAT_BIT_OVR    = 3;

    typedef struct packed {
        logic ack_release;
        logic force_set;
        logic force_clr;
        logic ovr_clr;
    } pp_cmd_t;

    // field order gives bit3..bit0 of the status register
    typedef struct packed {
        logic overrun;
        logic forced;
        logic busy;
        logic pending;
    } pp_status_t;

    function automatic pp_cmd_t decode_cmd(input logic wr, input logic [1:0] addr,
                                           input logic [3:0] wd);
        pp_cmd_t c;
        c.ack_release = wr && (addr == ADDR_CMD) && wd[CMD_BIT_RELEASE];
        c.force_set   = wr && (addr == ADDR_CMD) && wd[CMD_BIT_FSET];
        c.force_clr   = wr && (addr == ADDR_CMD) && wd[CMD_BIT_FCLR];
        c.ovr_clr     = wr && (addr == ADDR_STAT) && wd[STAT_BIT_OVR];
        return c;
    endfunction

    function automatic logic [3:0] status_bits(input pp_status_t s);
        return s;
    endfunction

endpackage

// File: rtl/pp_strobe_sync.sv
module pp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sh_q <= 1'b1;
                else     sh_q <= strobe_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], strobe_n};
            end
        end
    endgenerate

    assign level = sh_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end

    assign fall = prev_q & ~level;
    assign rise = ~prev_q & level;
endmodule

// File: rtl/pp_handshake.sv
module pp_handshake
    import pp_rx_pkg::*;
#(
    parameter int ACK_CYCLES = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe_fall,
    input  logic    strobe_rise,
    input  pp_cmd_t cmd,
    output logic    busy,
    output logic    ack_n,
    output logic    capture,
    output logic    ovr_set,
    output logic    forced
);
    localparam int CNT_W = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_CYCLES - 1);

    hs_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             forced_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        capture = 1'b0;
        ovr_set = 1'b0;
        case (state_q)
            HS_IDLE: begin
                if (strobe_fall) begin
                    if (forced_q) ovr_set = 1'b1;
                    else          state_d = HS_WAIT_RISE;
                end
            end
            HS_WAIT_RISE: begin
                if (strobe_rise) begin
                    capture = 1'b1;
                    state_d = HS_HOLD;
                end
            end
            HS_HOLD: begin
                if (strobe_fall) ovr_set = 1'b1;
                if (cmd.ack_release) begin
                    state_d = HS_ACK;
                    cnt_d   = '0;
                end
            end
            HS_ACK: begin
                if (strobe_fall) ovr_set = 1'b1;
                if (cnt_q == CNT_LAST) state_d = HS_IDLE;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= HS_IDLE;
            cnt_q    <= '0;
            forced_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (cmd.force_set)      forced_q <= 1'b1;
            else if (cmd.force_clr) forced_q <= 1'b0;
        end
    end

    assign busy   = (state_q != HS_IDLE) | forced_q;
    assign ack_n  = (state_q != HS_ACK);
    assign forced = forced_q;
endmodule

// File: rtl/pp_regs.sv
module pp_regs
    import pp_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_data,
    input  logic              capture,
    input  logic              ovr_set,
    input  logic              busy,
    input  logic              forced,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output pp_cmd_t           cmd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              rd, wr, rd_data_hit;
    logic [DATA_W-1:0] hold_q;
    logic              pending_q, overrun_q;
    pp_status_t        stat;
    logic              unused_wdata_hi;

    assign rd          = bus_sel & ~bus_we;
    assign wr          = bus_sel & bus_we;
    assign rd_data_hit = rd && (bus_addr == ADDR_DATA);
    assign cmd         = decode_cmd(wr, bus_addr, bus_wdata[3:0]);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:4];

    assign stat.overrun = overrun_q;
    assign stat.forced  = forced;
    assign stat.busy    = busy;
    assign stat.pending = pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            pending_q <= 1'b0;
            overrun_q <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (capture) hold_q <= host_data;
            // a fresh capture outranks the clear from a concurrent read
            if (capture)          pending_q <= 1'b1;
            else if (rd_data_hit) pending_q <= 1'b0;
            if (ovr_set)          overrun_q <= 1'b1;
            else if (cmd.ovr_clr) overrun_q <= 1'b0;
            if (rd) begin
                case (bus_addr)
                    ADDR_DATA: bus_rdata <= hold_q;
                    ADDR_STAT: bus_rdata <= DATA_W'(status_bits(stat));
                    default:   bus_rdata <= '0;
                endcase
            end
        end
    end

    assign irq = pending_q;
endmodule

// File: rtl/pp_rx_port.sv
module pp_rx_port
    import pp_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ACK_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_strobe_n,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_busy,
    output logic              host_ack_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic    stb_fall, stb_rise;
    logic    cap_pulse, ovr_pulse, hs_forced;
    pp_cmd_t cmd_w;

    pp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (host_strobe_n),
        .fall     (stb_fall),
        .rise     (stb_rise)
    );

    pp_handshake #(.ACK_CYCLES(ACK_CYCLES)) u_hs (
        .clk         (clk),
        .rst         (rst),
        .strobe_fall (stb_fall),
        .strobe_rise (stb_rise),
        .cmd         (cmd_w),
        .busy        (host_busy),
        .ack_n       (host_ack_n),
        .capture     (cap_pulse),
        .ovr_set     (ovr_pulse),
        .forced      (hs_forced)
    );

    pp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .host_data (host_data),
        .capture   (cap_pulse),
        .ovr_set   (ovr_pulse),
        .busy      (host_busy),
        .forced    (hs_forced),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd_w),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/pp_rx_port_chk.sv
module pp_rx_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_busy,
    input logic       host_ack_n,
    input logic       irq,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic       wdata_b0,
    input logic       forced
);
    AST_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !host_ack_n |-> host_busy); // R4

    AST_ACK_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        $fell(host_ack_n) |-> $past(bus_sel && bus_we && bus_addr == 2'd2 && wdata_b0)); // R4

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(host_busy) |-> ($past(!host_ack_n) || $past(forced))); // R5

    AST_FORCED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        forced |-> host_busy); // R6

    AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(host_busy)); // R3
endmodule

bind pp_rx_port pp_rx_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_busy  (host_busy),
    .host_ack_n (host_ack_n),
    .irq        (irq),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wdata_b0   (bus_wdata[0]),
    .forced     (hs_forced)
);

// File: tb/pp_rx_port_tb.sv
`timescale 1ns/1ps
module pp_rx_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_strobe_n = 1'b1;
    logic [7:0] host_data = 8'h00;
    logic       host_busy, host_ack_n, irq;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    pp_rx_port u_dut (
        .clk(clk), .rst(rst), .host_strobe_n(host_strobe_n), .host_data(host_data),
        .host_busy(host_busy), .host_ack_n(host_ack_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard monitor: every data-register read is compared with the queue head
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && bus_sel && !bus_we && bus_addr == 2'd0) begin
                @(negedge clk);
                if (exp_q.size() == 0) chk("R2", "data read with empty scoreboard", 1, 0);
                else chk("R2", "data register byte", int'(bus_rdata), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic cpu_read_data();
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'd0;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_status(input string req, input logic [7:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'd1;
        @(negedge clk);
        bus_sel = 1'b0;
        chk(req, "status register", int'(bus_rdata), int'(exp));
    endtask

    // host driver; push=0 for a strobe the block is expected to drop
    task automatic host_send(input logic [7:0] b, input bit push);
        @(negedge clk);
        host_data = b; host_strobe_n = 1'b0;
        if (push) exp_q.push_back(b);
        repeat (4) @(negedge clk);
        chk("R2", "busy during strobe", int'(host_busy), 1);
        host_strobe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // strobe whose capture edge coincides with a data-register read
    task automatic host_send_collide(input logic [7:0] b);
        @(negedge clk);
        host_data = b; host_strobe_n = 1'b0;
        exp_q.push_back(b);
        repeat (4) @(negedge clk);
        host_strobe_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'd0;
        @(negedge clk);
        bus_sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ack_and_check(input logic exp_busy_after);
        cpu_write(2'd2, 8'h01);
        for (int i = 0; i < 8; i++) begin
            chk("R4", "ack low during pulse", int'(host_ack_n), 0);
            @(negedge clk);
        end
        chk("R4", "ack high after pulse", int'(host_ack_n), 1);
        chk("R5", "busy after ack pulse", int'(host_busy), int'(exp_busy_after));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "busy after reset", int'(host_busy), 0);
        chk("R1", "ack after reset", int'(host_ack_n), 1);
        chk("R1", "irq after reset", int'(irq), 0);
        check_status("R1", 8'h00);

        // basic receive, read, release
        host_send(8'hA5, 1'b1);
        chk("R3", "irq after capture", int'(irq), 1);
        check_status("R8", 8'h03);
        cpu_read_data();
        chk("R3", "irq after data read", int'(irq), 0);
        ack_and_check(1'b0);

        // release command with nothing held
        cpu_write(2'd2, 8'h01);
        chk("R4", "ack with no byte held", int'(host_ack_n), 1);
        @(negedge clk);
        chk("R4", "ack with no byte held, later", int'(host_ack_n), 1);

        // forced busy survives the acknowledge
        host_send(8'h3C, 1'b1);
        cpu_read_data();
        cpu_write(2'd2, 8'h02);
        ack_and_check(1'b1);
        check_status("R6", 8'h06);
        host_send(8'hEE, 1'b0);
        chk("R7", "irq after dropped strobe", int'(irq), 0);
        check_status("R7", 8'h0E);
        cpu_write(2'd1, 8'h08);
        check_status("R7", 8'h06);
        cpu_write(2'd2, 8'h06);
        chk("R6", "set wins over clear", int'(host_busy), 1);
        cpu_write(2'd2, 8'h04);
        chk("R6", "busy after force cleared", int'(host_busy), 0);

        // capture and data read in the same cycle
        host_send(8'h11, 1'b1);
        ack_and_check(1'b0);
        host_send_collide(8'h22);
        chk("R3", "irq after colliding read", int'(irq), 1);
        cpu_read_data();
        chk("R3", "irq after second read", int'(irq), 0);
        ack_and_check(1'b0);

        // strobe while a byte is held is dropped
        host_send(8'h55, 1'b1);
        host_send(8'h66, 1'b0);
        chk("R7", "irq held across dropped strobe", int'(irq), 1);
        check_status("R7", 8'h0B);
        cpu_read_data();
        cpu_write(2'd1, 8'h08);
        ack_and_check(1'b0);
        check_status("R7", 8'h00);

        // assorted data patterns
        for (int k = 0; k < 4; k++) begin
            host_send(8'h5A ^ (8'h3F << k), 1'b1);
            cpu_read_data();
            ack_and_check(1'b0);
        end
        host_send(8'h00, 1'b1);
        cpu_read_data();
        ack_and_check(1'b0);
        host_send(8'hFF, 1'b1);
        cpu_read_data();
        ack_and_check(1'b0);

        repeat (4) @(negedge clk);
        chk("R2", "scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule